// File: doc/BRIEF.md
# Base Address Register Probe Sequencer

This block walks the six base address register slots of one configuration-space function and reports what each slot decodes. A start pulse, with a function identifier, launches the walk. The sequencer then issues 32-bit read and write requests on a request/acknowledge configuration master port. It only ever addresses the function that was latched at start.

Each slot is read and classified as I/O, 32-bit memory, 64-bit memory or reserved. A slot that is not reserved is sized by writing all ones and reading the result back. A slot whose readback is zero is unimplemented and is passed over. For every other slot the original value is written back and read again. The block then emits one record on a valid-qualified stream, carrying the space flag, a 64-bit start address and the decoded size. A 64-bit memory slot also reads the next dword as the upper address half and consumes both slots.

When the last slot has been handled, a single-cycle done pulse marks the end of the walk. A configuration access that returns an error stops the walk at once and raises an error flag in the same cycle as done.

Top module: `bar_probe_seq`

## Requirements
- R1: After reset busy, done, errFlag, recValid and cfgReq are low. A start pulse while idle raises busy, which stays high until the cycle after done.
- R2: Accesses carry the funcId latched at start. A later change of funcId, or a start pulse while busy, has no effect. Slot offsets begin at 0x10 and the walk ends once the next slot offset would exceed 0x24. Every access offset is dword aligned and within 0x10..0x28.
- R3: Bit 0 of the first read selects I/O space. A memory slot with bits 2:1 = 00 is 32-bit and with 10 is 64-bit. A memory slot with bits 2:1 = 01 or 11 is reserved: it gets no write and no record, and the walk steps by 4.
- R4: Sizing writes 0xFFFFFFFF and reads back. A readback of zero gives no record and no restore write, and the walk steps 8 for a 64-bit slot and 4 otherwise. A slot skipped this way is never accessed.
- R5: For an implemented slot the original value is written back, so after the walk every such slot holds its first-read value and has seen exactly two writes.
- R6: recSize is the lowest set bit of the sizing readback, with bits 1:0 cleared for I/O and bits 3:0 cleared for memory.
- R7: recAddr[31:0] is the re-read value with bits 3:0 cleared. For a 64-bit slot recAddr[63:32] is the dword at offset+4, read once and never written, and the walk steps by 8; otherwise recAddr[63:32] is zero. A record is emitted even when the address is zero.
- R8: Records appear in ascending slot order, one per implemented slot. done is high for exactly one cycle per walk.
- R9: An access acknowledged with cfgErr ends the walk. After it there are no further accesses and no further records, and done is raised with errFlag in the same cycle. errFlag is never high without done.
- R10: While cfgReq is high and not yet acknowledged, cfgWrite, cfgOffset, cfgWdata and cfgFunc hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (ignored while busy) |
| funcId | input | FUNC_W | Function identifier latched at start |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| errFlag | output | 1 | High with done when the walk was aborted |
| cfgReq | output | 1 | Configuration access request |
| cfgWrite | output | 1 | 1 = write, 0 = read |
| cfgFunc | output | FUNC_W | Target function of the access |
| cfgOffset | output | OFF_W | Dword-aligned configuration offset |
| cfgWdata | output | 32 | Write data |
| cfgAck | input | 1 | Access completed this cycle |
| cfgErr | input | 1 | Access failed (valid with cfgAck) |
| cfgRdata | input | 32 | Read data (valid with cfgAck) |
| recValid | output | 1 | Record valid for this cycle |
| recIsIo | output | 1 | Record describes I/O space |
| recAddr | output | 64 | Record start address |
| recSize | output | 32 | Record size in bytes |

## Verification
A wrong class decode or a wrong slot step shows up at the configuration port within one access. It appears as a write to a reserved slot, a read of a skipped upper dword, or an offset out of order. It also shifts every later record, so the record stream diverges at the next emission. A stale sizing or address capture gives a wrong recSize or recAddr on the record of the same slot. Sweeping hundreds of mixed slot layouts against a model configuration space checks record contents, the access counts per dword and the final register contents after every walk. Directed runs add error aborts at chosen accesses and mid-walk start pulses.

// File: rtl/bar_probe_pkg.sv
package bar_probe_pkg;

  localparam int DATA_W = 32;
  localparam logic [DATA_W-1:0] ALL_ONES = '1;
  localparam logic [DATA_W-1:0] IO_KEEP = ~32'h3;
  localparam logic [DATA_W-1:0] MEM_KEEP = ~32'hF;

  // which access the control is presenting
  typedef enum logic [2:0] {
    OP_RD_ORIG,
    OP_WR_ONES,
    OP_RD_SIZE,
    OP_WR_REST,
    OP_RD_BACK,
    OP_RD_HIGH
  } op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic start;
    logic capOrig;
    logic capSize;
    logic capLow;
    logic capHigh;
    logic advance;
    op_e  op;
  } ctl_t;

  // status from datapath to control
  typedef struct packed {
    logic rdReserved;
    logic rdZero;
    logic is64;
    logic lastSlot;
  } stat_t;

endpackage

// File: rtl/bar_probe_dp.sv
module bar_probe_dp
  import bar_probe_pkg::*;
#(
  parameter int FUNC_W = 16,
  parameter int OFF_W = 8,
  parameter logic [OFF_W-1:0] FIRST_OFF = 8'h10,
  parameter logic [OFF_W-1:0] LAST_OFF = 8'h24
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctl_t                ctl,
  input  logic [FUNC_W-1:0]   funcIdIn,
  input  logic [DATA_W-1:0]   cfgRdata,
  output stat_t               stat,
  output logic [FUNC_W-1:0]   cfgFunc,
  output logic [OFF_W-1:0]    cfgOffset,
  output logic [DATA_W-1:0]   cfgWdata,
  output logic                recIsIo,
  output logic [2*DATA_W-1:0] recAddr,
  output logic [DATA_W-1:0]   recSize
);

  localparam logic [OFF_W-1:0] STEP_ONE = OFF_W'(4);
  localparam logic [OFF_W-1:0] STEP_TWO = OFF_W'(8);

  logic [FUNC_W-1:0] funcReg;
  logic [OFF_W-1:0]  offReg;
  logic [DATA_W-1:0] origReg;
  logic [DATA_W-1:0] maskReg;
  logic [DATA_W-1:0] lowReg;
  logic [DATA_W-1:0] highReg;
  logic              isIoReg;
  logic              is64Reg;
  logic [OFF_W-1:0]  step;
  logic [OFF_W:0]    nextOff;

  assign step    = is64Reg ? STEP_TWO : STEP_ONE;
  assign nextOff = {1'b0, offReg} + {1'b0, step};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      funcReg <= '0;
      offReg  <= FIRST_OFF;
      origReg <= '0;
      maskReg <= '0;
      lowReg  <= '0;
      highReg <= '0;
      isIoReg <= 1'b0;
      is64Reg <= 1'b0;
    end else begin
      if (ctl.start) begin
        funcReg <= funcIdIn;
        offReg  <= FIRST_OFF;
      end
      if (ctl.capOrig) begin
        origReg <= cfgRdata;
        isIoReg <= cfgRdata[0];
        is64Reg <= !cfgRdata[0] && (cfgRdata[2:1] == 2'b10);
        highReg <= '0;
      end
      if (ctl.capSize) maskReg <= cfgRdata & (isIoReg ? IO_KEEP : MEM_KEEP);
      if (ctl.capLow)  lowReg  <= cfgRdata & MEM_KEEP;
      if (ctl.capHigh) highReg <= cfgRdata;
      if (ctl.advance) offReg  <= nextOff[OFF_W-1:0];
    end
  end

  always_comb begin
    stat.rdReserved = !cfgRdata[0] && cfgRdata[1];
    stat.rdZero     = (cfgRdata == '0);
    stat.is64       = is64Reg;
    stat.lastSlot   = nextOff > {1'b0, LAST_OFF};
  end

  assign cfgFunc   = funcReg;
  assign cfgOffset = (ctl.op == OP_RD_HIGH) ? offReg + STEP_ONE : offReg;
  assign cfgWdata  = (ctl.op == OP_WR_ONES) ? ALL_ONES : origReg;

  assign recIsIo = isIoReg;
  assign recAddr = {highReg, lowReg};
  assign recSize = maskReg & (~maskReg + 1'b1);

  // a captured 64-bit class always has memory space
  AST_IO_NOT_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    is64Reg |-> !isIoReg); // R3

endmodule

// File: rtl/bar_probe_ctrl.sv
module bar_probe_ctrl
  import bar_probe_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  input  logic  cfgAck,
  input  logic  cfgErr,
  input  stat_t stat,
  output ctl_t  ctl,
  output logic  cfgReq,
  output logic  cfgWrite,
  output logic  busy,
  output logic  done,
  output logic  errFlag,
  output logic  recValid
);

  typedef enum logic [3:0] {
    S_IDLE, S_RD_ORIG, S_WR_ONES, S_RD_SIZE, S_WR_REST,
    S_RD_BACK, S_RD_HIGH, S_EMIT, S_ADV, S_FINISH
  } state_e;

  state_e state, nextState;
  logic   errReg, errSet;
  logic   failAck;

  assign failAck = cfgAck && cfgErr;

  always_comb begin
    ctl       = '0;
    ctl.op    = OP_RD_ORIG;
    cfgReq    = 1'b0;
    cfgWrite  = 1'b0;
    errSet    = 1'b0;
    nextState = state;
    unique case (state)
      S_IDLE: if (start) begin
        ctl.start = 1'b1;
        nextState = S_RD_ORIG;
      end
      S_RD_ORIG: begin
        cfgReq = 1'b1;
        ctl.op = OP_RD_ORIG;
        if (failAck) begin errSet = 1'b1; nextState = S_FINISH; end
        else if (cfgAck) begin
          ctl.capOrig = 1'b1;
          nextState = stat.rdReserved ? S_ADV : S_WR_ONES;
        end
      end
      S_WR_ONES: begin
        cfgReq = 1'b1; cfgWrite = 1'b1;
        ctl.op = OP_WR_ONES;
        if (failAck) begin errSet = 1'b1; nextState = S_FINISH; end
        else if (cfgAck) nextState = S_RD_SIZE;
      end
      S_RD_SIZE: begin
        cfgReq = 1'b1;
        ctl.op = OP_RD_SIZE;
        if (failAck) begin errSet = 1'b1; nextState = S_FINISH; end
        else if (cfgAck) begin
          ctl.capSize = 1'b1;
          nextState = stat.rdZero ? S_ADV : S_WR_REST;
        end
      end
      S_WR_REST: begin
        cfgReq = 1'b1; cfgWrite = 1'b1;
        ctl.op = OP_WR_REST;
        if (failAck) begin errSet = 1'b1; nextState = S_FINISH; end
        else if (cfgAck) nextState = S_RD_BACK;
      end
      S_RD_BACK: begin
        cfgReq = 1'b1;
        ctl.op = OP_RD_BACK;
        if (failAck) begin errSet = 1'b1; nextState = S_FINISH; end
        else if (cfgAck) begin
          ctl.capLow = 1'b1;
          nextState = stat.is64 ? S_RD_HIGH : S_EMIT;
        end
      end
      S_RD_HIGH: begin
        cfgReq = 1'b1;
        ctl.op = OP_RD_HIGH;
        if (failAck) begin errSet = 1'b1; nextState = S_FINISH; end
        else if (cfgAck) begin
          ctl.capHigh = 1'b1;
          nextState = S_EMIT;
        end
      end
      S_EMIT: nextState = S_ADV;
      S_ADV: begin
        ctl.advance = 1'b1;
        nextState = stat.lastSlot ? S_FINISH : S_RD_ORIG;
      end
      S_FINISH: nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      errReg <= 1'b0;
    end else begin
      state <= nextState;
      if (ctl.start)   errReg <= 1'b0;
      else if (errSet) errReg <= 1'b1;
    end
  end

  assign busy     = (state != S_IDLE);
  assign done     = (state == S_FINISH);
  assign errFlag  = done && errReg;
  assign recValid = (state == S_EMIT);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !cfgReq && !recValid && !done); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> done); // R9
  AST_STOP_AFTER_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReq && cfgAck && cfgErr) |=> !cfgReq && !recValid && done); // R9

endmodule

// File: rtl/bar_probe_seq.sv
module bar_probe_seq
  import bar_probe_pkg::*;
#(
  parameter int FUNC_W = 16,
  parameter int OFF_W = 8,
  parameter logic [OFF_W-1:0] FIRST_OFF = 8'h10,
  parameter logic [OFF_W-1:0] LAST_OFF = 8'h24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [FUNC_W-1:0] funcId,
  output logic              busy,
  output logic              done,
  output logic              errFlag,
  output logic              cfgReq,
  output logic              cfgWrite,
  output logic [FUNC_W-1:0] cfgFunc,
  output logic [OFF_W-1:0]  cfgOffset,
  output logic [31:0]       cfgWdata,
  input  logic              cfgAck,
  input  logic              cfgErr,
  input  logic [31:0]       cfgRdata,
  output logic              recValid,
  output logic              recIsIo,
  output logic [63:0]       recAddr,
  output logic [31:0]       recSize
);

  localparam logic [OFF_W-1:0] TOP_OFF = LAST_OFF + OFF_W'(4);

  ctl_t  ctl;
  stat_t stat;

  bar_probe_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .cfgAck(cfgAck), .cfgErr(cfgErr), .stat(stat),
    .ctl(ctl), .cfgReq(cfgReq), .cfgWrite(cfgWrite),
    .busy(busy), .done(done), .errFlag(errFlag), .recValid(recValid)
  );

  bar_probe_dp #(
    .FUNC_W(FUNC_W), .OFF_W(OFF_W),
    .FIRST_OFF(FIRST_OFF), .LAST_OFF(LAST_OFF)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .funcIdIn(funcId), .cfgRdata(cfgRdata), .stat(stat),
    .cfgFunc(cfgFunc), .cfgOffset(cfgOffset), .cfgWdata(cfgWdata),
    .recIsIo(recIsIo), .recAddr(recAddr), .recSize(recSize)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReq && !cfgAck) |=> cfgReq && $stable(cfgWrite) && $stable(cfgOffset)
      && $stable(cfgWdata) && $stable(cfgFunc)); // R10
  AST_OFF_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    cfgReq |-> (cfgOffset >= FIRST_OFF) && (cfgOffset <= TOP_OFF)
      && (cfgOffset[1:0] == 2'b00)); // R2
  AST_NARROW_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (recValid && recIsIo) |-> (recAddr[63:32] == '0)); // R7

endmodule

// File: tb/bar_probe_seq_test.sv
module bar_probe_seq_test;
  localparam int FW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic          start = 1'b0;
  logic [FW-1:0] funcId = '0;
  logic          busy, done, errFlag, cfgReq, cfgWrite;
  logic [FW-1:0] cfgFunc;
  logic [7:0]    cfgOffset;
  logic [31:0]   cfgWdata;
  logic          cfgAck = 1'b0;
  logic          cfgErr = 1'b0;
  logic [31:0]   cfgRdata = '0;
  logic          recValid, recIsIo;
  logic [63:0]   recAddr;
  logic [31:0]   recSize;

  bar_probe_seq uut (
    .clk(clk), .rstN(rstN), .start(start), .funcId(funcId),
    .busy(busy), .done(done), .errFlag(errFlag),
    .cfgReq(cfgReq), .cfgWrite(cfgWrite), .cfgFunc(cfgFunc),
    .cfgOffset(cfgOffset), .cfgWdata(cfgWdata),
    .cfgAck(cfgAck), .cfgErr(cfgErr), .cfgRdata(cfgRdata),
    .recValid(recValid), .recIsIo(recIsIo), .recAddr(recAddr), .recSize(recSize)
  );

  int nChecks = 0;
  int nErr = 0;

  // model configuration space, dwords 0x10..0x28
  logic [31:0] mVal[7], mWm[7], mHw[7], mOrig[7];
  int mWr[7], mRd[7], kindOf[7];
  bit          expIo[8];
  logic [63:0] expAddr[8];
  logic [31:0] expSize[8];
  int expN, gotN, doneCnt, errCnt;
  int accCount, errAt, funcBad, reqBad, offBad;
  logic [FW-1:0] curFunc;

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pushExp(input bit io, input logic [63:0] a, input logic [31:0] sz);
    expIo[expN] = io; expAddr[expN] = a; expSize[expN] = sz;
    expN++;
  endtask

  // kinds: 0 unimpl, 1 io, 2 mem32, 3 mem64, 4 reserved, 5 dead 64-bit
  // upper dwords: 6 = upper of mem64, 7 = skipped upper of dead 64-bit
  task automatic buildCfg(input int code);
    int c, s, k, e;
    logic [31:0] sz, base, hiv;
    c = code; s = 0; expN = 0;
    for (int i = 0; i < 7; i++) begin
      mVal[i] = '0; mWm[i] = '0; mHw[i] = '0; mWr[i] = 0; mRd[i] = 0; kindOf[i] = -1;
    end
    while (s <= 5) begin
      k = c % 6; c = c / 6; e = (code + s * 5) % 12;
      base = (code % 4 == 0) ? 32'h0 : 32'h9E3779B9 * 32'(s + code + 1);
      kindOf[s] = k;
      case (k)
        1: begin
          sz = 32'd4 << e;
          mHw[s] = 32'h1; mWm[s] = ~(sz - 1) & ~32'h3;
          mVal[s] = (base & mWm[s]) | 32'h1;
          pushExp(1'b1, {32'h0, mVal[s] & ~32'hF}, sz);
          s += 1;
        end
        2, 3: begin
          sz = 32'd16 << e;
          mHw[s] = ((e % 2 == 1) ? 32'h8 : 32'h0) | ((k == 3) ? 32'h4 : 32'h0);
          mWm[s] = ~(sz - 1);
          mVal[s] = (base & mWm[s]) | mHw[s];
          hiv = '0;
          if (k == 3) begin
            hiv = (code % 4 == 0) ? 32'h0 : 32'h100 + 32'(s);
            mWm[s+1] = '1; mVal[s+1] = hiv; kindOf[s+1] = 6;
          end
          pushExp(1'b0, {hiv, mVal[s] & ~32'hF}, sz);
          s += (k == 3) ? 2 : 1;
        end
        4: begin
          mVal[s] = 32'h5000 | 32'h2 | ((e % 2 == 1) ? 32'h4 : 32'h0);
          s += 1;
        end
        5: begin
          mVal[s] = 32'h4; mVal[s+1] = 32'h1; kindOf[s+1] = 7;
          s += 2;
        end
        default: s += 1;
      endcase
    end
    for (int i = 0; i < 7; i++) mOrig[i] = mVal[i];
  endtask

  // configuration space responder
  initial begin
    forever begin : resp
      logic [7:0] o;
      logic w;
      logic [31:0] wd;
      int idx, lat;
      @(negedge clk);
      if (cfgReq && rstN) begin
        o = cfgOffset; w = cfgWrite; wd = cfgWdata;
        accCount++;
        lat = accCount % 3;
        if (cfgFunc != curFunc) funcBad++;
        repeat (lat) begin
          @(negedge clk);
          if (!cfgReq || cfgOffset != o || cfgWrite != w || cfgWdata != wd) reqBad++;
        end
        cfgAck = 1'b1;
        cfgErr = (accCount == errAt);
        if (o < 8'h10 || o > 8'h28 || o[1:0] != 2'b00) begin
          offBad++; cfgRdata = '0;
        end else begin
          idx = (int'(o) - 16) / 4;
          if (!cfgErr) begin
            if (w) begin mVal[idx] = (wd & mWm[idx]) | mHw[idx]; mWr[idx]++; end
            else begin cfgRdata = mVal[idx]; mRd[idx]++; end
          end
        end
        @(negedge clk);
        cfgAck = 1'b0; cfgErr = 1'b0;
      end
    end
  end

  // record and completion monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (recValid) begin
        if (gotN < expN) begin
          check(recIsIo == expIo[gotN], "R3 space flag", 64'(recIsIo), 64'(expIo[gotN]));
          check(recAddr == expAddr[gotN], "R7 start address", recAddr, expAddr[gotN]);
          check(recSize == expSize[gotN], "R6 size", 64'(recSize), 64'(expSize[gotN]));
        end else begin
          check(1'b0, "R8 extra record", 64'(gotN), 64'(expN));
        end
        gotN++;
      end
      if (done) doneCnt++;
      if (done && errFlag) errCnt++;
      if (errFlag && !done) check(1'b0, "R9 error without done", 1, 0);
    end
  end

  task automatic runWalk(input logic [FW-1:0] f, input int dupAt);
    curFunc = f; gotN = 0; doneCnt = 0; errCnt = 0; accCount = 0;
    funcBad = 0; reqBad = 0; offBad = 0;
    @(negedge clk);
    start = 1'b1; funcId = f;
    @(negedge clk);
    start = 1'b0; funcId = ~f;
    check(busy == 1'b1, "R1 busy during walk", 64'(busy), 1);
    for (int t = 0; t < 3000 && doneCnt == 0; t++) begin
      start = (dupAt > 0 && t == dupAt);
      @(negedge clk);
    end
    start = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic checkRun(input int wantRecs, input bit wantErr, input int wantAcc);
    check(doneCnt == 1, "R8 done pulses", 64'(doneCnt), 1);
    check(errCnt == (wantErr ? 1 : 0), "R9 error flag", 64'(errCnt), 64'(wantErr));
    check(gotN == wantRecs, "R8 record count", 64'(gotN), 64'(wantRecs));
    check(funcBad == 0, "R2 function id", 64'(funcBad), 0);
    check(offBad == 0, "R2 offset window", 64'(offBad), 0);
    check(reqBad == 0, "R10 request hold", 64'(reqBad), 0);
    check(busy == 1'b0, "R1 idle after done", 64'(busy), 0);
    if (wantErr) begin
      check(accCount == wantAcc, "R9 no access after error", 64'(accCount), 64'(wantAcc));
    end else begin
      for (int i = 0; i < 7; i++) begin
        case (kindOf[i])
          0: check(mWr[i] == 1, "R4 unimplemented sized only", 64'(mWr[i]), 1);
          1, 2, 3: begin
            check(mVal[i] == mOrig[i], "R5 restored value", 64'(mVal[i]), 64'(mOrig[i]));
            check(mWr[i] == 2, "R5 write count", 64'(mWr[i]), 2);
          end
          4: begin
            check(mWr[i] == 0, "R3 reserved not written", 64'(mWr[i]), 0);
            check(mRd[i] == 1, "R3 reserved read once", 64'(mRd[i]), 1);
          end
          5: check(mWr[i] == 1, "R4 dead 64-bit no restore", 64'(mWr[i]), 1);
          6: check(mWr[i] == 0 && mRd[i] == 1, "R7 upper dword read once",
                   64'(mRd[i] * 16 + mWr[i]), 16);
          7: check(mWr[i] == 0 && mRd[i] == 0, "R4 skipped upper slot",
                   64'(mRd[i] * 16 + mWr[i]), 0);
          default: ;
        endcase
      end
    end
  endtask

  initial begin
    expN = 0; gotN = 0; doneCnt = 0; errCnt = 0; accCount = 0; errAt = 0;
    funcBad = 0; reqBad = 0; offBad = 0; curFunc = '0;
    for (int i = 0; i < 7; i++) begin
      mVal[i] = '0; mWm[i] = '0; mHw[i] = '0; mOrig[i] = '0;
      mWr[i] = 0; mRd[i] = 0; kindOf[i] = -1;
    end
    repeat (4) @(negedge clk);
    check(busy == 0 && done == 0 && errFlag == 0, "R1 reset outputs",
          64'({busy, done, errFlag}), 0);
    check(cfgReq == 0 && recValid == 0, "R1 reset port quiet", 64'({cfgReq, recValid}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // three 64-bit memory slots
    buildCfg(129); runWalk(16'h0A11, 0); checkRun(expN, 0, 0);
    // nothing implemented
    buildCfg(0); runWalk(16'h0B22, 0); checkRun(0, 0, 0);
    // start pulse and funcId change mid-walk are ignored (R2)
    buildCfg(2 + 1 * 6 + 3 * 36); runWalk(16'h0C33, 8); checkRun(expN, 0, 0);

    // error on the sizing write of slot 1: one record, then abort (R9)
    buildCfg(2); errAt = 7; runWalk(16'h0D44, 0); checkRun(1, 1, 7);
    // error on the very first access
    buildCfg(2); errAt = 1; runWalk(16'h0E55, 0); checkRun(0, 1, 1);
    errAt = 0;
    // normal walk after an aborted one clears the flag
    buildCfg(2); runWalk(16'h0F66, 0); checkRun(1, 0, 0);

    // sweep of mixed slot layouts
    for (int n = 0; n < 300; n++) begin
      buildCfg((n * 7919 + 13) % 46656);
      runWalk(FW'(n * 37), 0);
      checkRun(expN, 0, 0);
    end

    $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nErr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end

endmodule